// File: doc/BRIEF.md
# Statistics Counter Bank with Read-Clear and Test Preset

This block holds a small bank of 32-bit statistics counters for a MAC port. Two kinds of counter sit in the bank. Event counters add one for each frame event: transmitted frames, received frames and good received frames. Length counters add the byte count of each frame: transmit bytes, receive bytes and good receive bytes. The MAC drives one strobe per counter. Each length strobe comes with a byte count on its own lane.

Software reads a counter through a plain register read port. It places an address and a one-cycle read strobe, and the data comes back one cycle later with a valid flag. Every read strobe is taken; the port has no back-pressure and no ready signal. Reading a counter also reloads it. In normal operation the reload value is zero. A counter-test mode, held in a one-bit register inside the block, changes the reload value to a point just below bit 31 of the counter. Software can then reach the high counts and the carry out of bit 30 in a few events. Event counters and length counters use different reload values in this mode.

Counter map for `rd_addr`: 0 transmit frames, 1 receive frames, 2 good receive frames, 3 transmit bytes, 4 receive bytes, 5 good receive bytes. Addresses 6 and 7 are unmapped.

Top module: `stat_cnt_bank`

## Requirements
- R1: After reset every counter is zero, the test mode is off, `rd_vld` is 0 and `rd_data` is 0.
- R2: An event counter (addresses 0 to 2) adds 1 on each cycle in which its bit of `evt_pulse` is high. Bit k feeds address k.
- R3: A length counter (addresses 3 to 5) adds the zero-extended 16-bit value on its lane of `len_bytes` on each cycle in which its bit of `len_pulse` is high. Bit j and lane j (bits 16j+15 to 16j) feed address 3+j.
- R4: A read strobe sets `rd_vld` to 1 in the next cycle. In that cycle `rd_data` holds the value the counter had in the cycle of the strobe, before the strobe changed it. With no strobe, `rd_vld` is 0 in the next cycle.
- R5: With test mode off, a read loads the counter with 0.
- R6: With test mode on, a read loads an event counter with 0x7FFF_FFFC.
- R7: With test mode on, a read loads a length counter with 0x7FFF_FF80.
- R8: An increment that arrives in the same cycle as a read of the same counter is added on top of the value loaded by the read.
- R9: Counters do not saturate. They add modulo 2^32, and a carry from bit 30 into bit 31 is an ordinary carry.
- R10: A read of an unmapped address (6 or 7) returns 0 with `rd_vld` 1 and changes no counter.
- R11: `mode_we` high loads `mode_wdata` into the test-mode bit, and the new mode applies to reads from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Write strobe for the test-mode bit |
| mode_wdata | input | 1 | New test-mode value (1 = preset on read) |
| evt_pulse | input | 3 | One strobe per event counter |
| len_pulse | input | 3 | One strobe per length counter |
| len_bytes | input | 48 | Frame byte counts, 16 bits per length counter |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | 3 | Counter address |
| rd_data | output | 32 | Counter value before the read side effect |
| rd_vld | output | 1 | `rd_data` is valid in this cycle |

## Verification
Each counter change lands on the clock edge that samples its strobe, so a read issued in the next cycle shows it. Read data and `rd_vld` appear one edge after the read strobe. The bench drives each stimulus vector on the falling edge. It samples `rd_vld` and `rd_data` just after the following rising edge, and checks each counter change through a later read. A read and an increment in the same cycle show up only at the second read, because the first read returns the value from before both changes.

// File: rtl/stat_cnt_pkg.sv
package stat_cnt_pkg;
  localparam int STAT_CNT_W = 32;
  localparam logic [STAT_CNT_W-1:0] EVT_TEST_PRESET = 32'h7FFF_FFFC;
  localparam logic [STAT_CNT_W-1:0] LEN_TEST_PRESET = 32'h7FFF_FF80;
endpackage

// File: rtl/stat_mode_reg.sv
module stat_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_we,
  input  logic mode_wdata,
  output logic test_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_mode <= 1'b0;
    else if (mode_we) test_mode <= mode_wdata;
  end

  // R11: a write takes effect on the next edge
  p_mode_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (test_mode == $past(mode_wdata)));
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(test_mode));
endmodule

// File: rtl/stat_cnt_cell.sv
module stat_cnt_cell #(
  parameter int CNT_W = 32,
  parameter int INC_W = 16,
  parameter logic [CNT_W-1:0] TEST_PRESET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [INC_W-1:0] inc_amt,
  input  logic             rd_hit,
  input  logic             test_mode,
  output logic [CNT_W-1:0] value
);
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    if (rd_hit) base = test_mode ? TEST_PRESET : '0;
    else        base = value;
    step = inc_en ? CNT_W'(inc_amt) : '0;
    nxt  = base + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= nxt;
  end

  // R5: read with test mode off reloads zero
  p_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !test_mode && !inc_en) |=> (value == '0));
  // R6 / R7: read with test mode on reloads this cell's preset
  p_read_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && test_mode && !inc_en) |=> (value == TEST_PRESET));
  // R8: same-cycle increment stacks on the reload value
  p_read_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && inc_en) |=>
      (value == (($past(test_mode) ? TEST_PRESET : '0) + CNT_W'($past(inc_amt)))));
  // R2 / R3 / R9: plain accumulate, modulo 2^CNT_W
  p_accum_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit && inc_en) |=> (value == $past(value) + CNT_W'($past(inc_amt))));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit && !inc_en) |=> $stable(value));
endmodule

// File: rtl/stat_rd_port.sv
module stat_rd_port #(
  parameter int CNT_W   = 32,
  parameter int NUM_CNT = 6,
  parameter int ADDR_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_vals,
  output logic [NUM_CNT-1:0]       rd_hit,
  output logic [CNT_W-1:0]         rd_data,
  output logic                     rd_vld
);
  logic [CNT_W-1:0] sel;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_dec
    assign rd_hit[k] = rd_en && (rd_addr == ADDR_W'(k));
  end

  always_comb begin
    sel = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (rd_hit[k]) sel = cnt_vals[k*CNT_W +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld  <= rd_en;
      rd_data <= rd_en ? sel : '0;
    end
  end

  // R4: valid follows the strobe by one edge
  p_rd_vld_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld);
  p_rd_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_vld);
  p_one_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hit));
  // R4: returned word is the pre-side-effect value
  p_rd_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (int'(rd_addr) < NUM_CNT)) |=>
      (rd_data == $past(cnt_vals[int'(rd_addr)*CNT_W +: CNT_W])));
  // R10: unmapped address reads zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (int'(rd_addr) >= NUM_CNT)) |=> (rd_data == '0));
endmodule

// File: rtl/stat_cnt_bank.sv
module stat_cnt_bank
  import stat_cnt_pkg::*;
#(
  parameter int CNT_W   = STAT_CNT_W,
  parameter int NUM_EVT = 3,
  parameter int NUM_LEN = 3,
  parameter int LEN_W   = 16,
  parameter int ADDR_W  = 3,
  parameter logic [CNT_W-1:0] EVT_PRESET = EVT_TEST_PRESET,
  parameter logic [CNT_W-1:0] LEN_PRESET = LEN_TEST_PRESET
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_we,
  input  logic                     mode_wdata,
  input  logic [NUM_EVT-1:0]       evt_pulse,
  input  logic [NUM_LEN-1:0]       len_pulse,
  input  logic [NUM_LEN*LEN_W-1:0] len_bytes,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [CNT_W-1:0]         rd_data,
  output logic                     rd_vld
);
  localparam int NUM_CNT = NUM_EVT + NUM_LEN;

  logic                     test_mode;
  logic [NUM_CNT-1:0]       rd_hit;
  logic [NUM_CNT*CNT_W-1:0] cnt_vals;

  stat_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .test_mode  (test_mode)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    stat_cnt_cell #(
      .CNT_W       (CNT_W),
      .INC_W       (1),
      .TEST_PRESET (EVT_PRESET)
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_en    (evt_pulse[i]),
      .inc_amt   (1'b1),
      .rd_hit    (rd_hit[i]),
      .test_mode (test_mode),
      .value     (cnt_vals[i*CNT_W +: CNT_W])
    );
  end

  for (genvar j = 0; j < NUM_LEN; j++) begin : g_len
    stat_cnt_cell #(
      .CNT_W       (CNT_W),
      .INC_W       (LEN_W),
      .TEST_PRESET (LEN_PRESET)
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_en    (len_pulse[j]),
      .inc_amt   (len_bytes[j*LEN_W +: LEN_W]),
      .rd_hit    (rd_hit[NUM_EVT+j]),
      .test_mode (test_mode),
      .value     (cnt_vals[(NUM_EVT+j)*CNT_W +: CNT_W])
    );
  end

  stat_rd_port #(
    .CNT_W   (CNT_W),
    .NUM_CNT (NUM_CNT),
    .ADDR_W  (ADDR_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .cnt_vals (cnt_vals),
    .rd_hit   (rd_hit),
    .rd_data  (rd_data),
    .rd_vld   (rd_vld)
  );

  // R10: an unmapped read leaves every counter untouched
  p_unmapped_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (int'(rd_addr) >= NUM_CNT) && !(|evt_pulse) && !(|len_pulse))
      |=> $stable(cnt_vals));
  // R1: reset leaves the read port idle on the first edge without a strobe
  p_idle_after_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !rd_vld) |=> (rd_data == '0));
endmodule

// File: tb/test_stat_cnt_bank.sv
module test_stat_cnt_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic        mode_wdata = 1'b0;
  logic [2:0]  evt_pulse = '0;
  logic [2:0]  len_pulse = '0;
  logic [47:0] len_bytes = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_vld;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  stat_cnt_bank i_stat_cnt_bank (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .evt_pulse(evt_pulse), .len_pulse(len_pulse), .len_bytes(len_bytes),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_vld(rd_vld)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  ev;
    logic [2:0]  lp;
    logic [15:0] l0;
    logic [15:0] l1;
    logic [15:0] l2;
    logic        rd;
    logic [2:0]  ad;
    logic        mw;
    logic        mv;
    logic        xv;
    logic [31:0] xd;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  3'b001, 3'b000, 16'd0,   16'd0,  16'd0,    1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'd0},          // R2
    '{4'd2,  3'b001, 3'b000, 16'd0,   16'd0,  16'd0,    1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'd0},
    '{4'd2,  3'b011, 3'b000, 16'd0,   16'd0,  16'd0,    1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'd0},
    '{4'd3,  3'b000, 3'b001, 16'd100, 16'd0,  16'd0,    1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'd0},          // R3
    '{4'd3,  3'b000, 3'b011, 16'd50,  16'd64, 16'd0,    1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'd0},
    '{4'd4,  3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 32'd3},          // R4 R2
    '{4'd5,  3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 32'd0},          // R5
    '{4'd3,  3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 32'd150},        // R3
    '{4'd8,  3'b000, 3'b001, 16'd20,  16'd0,  16'd0,    1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 32'd0},          // R8
    '{4'd8,  3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 32'd20},
    '{4'd2,  3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 32'd1},
    '{4'd10, 3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd7, 1'b0, 1'b0, 1'b1, 32'd0},          // R10
    '{4'd10, 3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 32'd64},
    '{4'd11, 3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 32'd0},          // R11
    '{4'd6,  3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 32'd0},          // R6
    '{4'd9,  3'b100, 3'b000, 16'd0,   16'd0,  16'd0,    1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'd0},          // R9
    '{4'd9,  3'b100, 3'b000, 16'd0,   16'd0,  16'd0,    1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'd0},
    '{4'd9,  3'b100, 3'b000, 16'd0,   16'd0,  16'd0,    1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'd0},
    '{4'd9,  3'b100, 3'b000, 16'd0,   16'd0,  16'd0,    1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 32'd0},
    '{4'd6,  3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 32'h8000_0000},  // R6 R9
    '{4'd7,  3'b000, 3'b100, 16'd0,   16'd0,  16'h0090, 1'b1, 3'd5, 1'b0, 1'b0, 1'b1, 32'd0},          // R7 R8
    '{4'd7,  3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd5, 1'b0, 1'b0, 1'b1, 32'h8000_0010},  // R7 R9
    '{4'd11, 3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 32'd0},          // R11
    '{4'd7,  3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd5, 1'b0, 1'b0, 1'b1, 32'h7FFF_FF80},
    '{4'd5,  3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd5, 1'b0, 1'b0, 1'b1, 32'd0},          // R5
    '{4'd8,  3'b010, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 32'd0},          // R8
    '{4'd8,  3'b000, 3'b000, 16'd0,   16'd0,  16'd0,    1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 32'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    evt_pulse = '0; len_pulse = '0; len_bytes = '0;
    rd_en = 1'b0; rd_addr = '0; mode_we = 1'b0; mode_wdata = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    idle();
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    check({tag, " valid"}, {31'd0, rd_vld}, 32'd1);
    check({tag, " data"}, rd_data, exp);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {31'd0, rd_vld}, 32'd0);
    check("R1 reset data", rd_data, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      evt_pulse  = VEC[i].ev;
      len_pulse  = VEC[i].lp;
      len_bytes  = {VEC[i].l2, VEC[i].l1, VEC[i].l0};
      rd_en      = VEC[i].rd;
      rd_addr    = VEC[i].ad;
      mode_we    = VEC[i].mw;
      mode_wdata = VEC[i].mv;
      @(posedge clk); #1;
      n_chk++;
      if (rd_vld !== VEC[i].xv || (VEC[i].xv && rd_data !== VEC[i].xd)) begin
        n_bad++;
        $display("FAIL R%0d vec %0d: got vld=%b data=%h expected vld=%b data=%h",
                 VEC[i].rq, i, rd_vld, rd_data, VEC[i].xv, VEC[i].xd);
      end
    end

    // R4: no strobe, no valid
    @(negedge clk); idle();
    @(posedge clk); #1;
    check("R4 idle valid", {31'd0, rd_vld}, 32'd0);

    // R6: event preset observed directly, mode on
    @(negedge clk); idle(); mode_we = 1'b1; mode_wdata = 1'b1;
    do_read(3'd0, 32'd0, "R6 first read");
    do_read(3'd0, 32'h7FFF_FFFC, "R6 preset read");
    // R7: length preset on receive bytes
    do_read(3'd4, 32'd0, "R7 first read");
    do_read(3'd4, 32'h7FFF_FF80, "R7 preset read");

    // R1 / R11: reset returns mode to off and counters to zero
    @(negedge clk); idle(); evt_pulse = 3'b111; len_pulse = 3'b111;
    len_bytes = {16'd9, 16'd9, 16'd9};
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 6; a++) begin
      do_read(3'(a), 32'd0, "R1 counter after reset");
    end
    do_read(3'd0, 32'd0, "R11 mode off after reset");
    do_read(3'd3, 32'd0, "R11 length mode off after reset");

    @(negedge clk); idle();
    summary();
  end
endmodule